// File: doc/BRIEF.md
# Power Management Event Status Logic

This block holds sticky status flags for four power-management events: an on-chip device wake request, an off-chip wake pin, a USB controller wake and a battery-low pin. All four event inputs are active-low. Each input passes through a two-flop synchroniser. A falling edge on the synchronised signal sets its flag. Software clears a flag by writing a one to its bit. Three of the flags have matching enable bits.

A small routing state machine turns the sleep-state code and the cause code for soft-off into one of four routing modes:

- `MODE_RUN`: the working state.
- `MODE_SLEEP`: sleeping, or soft-off entered through the sleep-enable path.
- `MODE_OFF_BUTTON`: soft-off entered by a power-button override.
- `MODE_OFF_POWER`: soft-off entered by a power failure.

The mode is recomputed on every clock. Every state has a transition to every other state, and the transition is chosen by the decoded inputs alone: `to_run`, `to_sleep`, `to_off_button` and `to_off_power`.

The mode, the SCI enable input and the enabled flags together drive three level outputs: an SCI, an SMI and a wake request.

Top module: `pm_evt_stat`

## Requirements
- R1: After `rst_n` is released, every status and enable bit reads 0 and `sci`, `smi` and `wake` are low.
- R2: A falling edge on an event input sets its status bit. The input must be sampled low at a clock edge, and the bit reads 1 after the second clock edge following that sample. The status bit positions are: on-chip wake at bit 13, USB wake at bit 12, wake pin at bit 11, battery-low at bit 10.
- R3: A status bit stays set until it is cleared. Holding the input low or returning it high does not clear the bit. An input held low does not set the bit again after it has been cleared.
- R4: A write with `reg_addr`=0 clears each status bit whose `reg_wdata` bit is 1. A status bit whose `reg_wdata` bit is 0 is left unchanged.
- R5: When a set and a write-one-to-clear reach the same bit on the same clock edge, the bit ends up set.
- R6: A write with `reg_addr`=1 loads the enable bits at positions 13, 12 and 11. Reads with `reg_addr`=1 return those enable bits, and every other bit position reads 0. Disabled flags never drive an output.
- R7: In `MODE_RUN` (sleep code 0, or the unused codes 6 and 7), any enabled flag drives `sci` when `sci_en`=1 and drives `smi` when `sci_en`=0. `wake` stays low in this mode.
- R8: In `MODE_SLEEP` (codes 1 to 4, or code 5 with cause 0), the following routing applies:
  - An enabled on-chip wake flag drives `wake`. It also drives `sci` or `smi`, chosen by `sci_en`.
  - An enabled wake-pin flag drives both `wake` and `sci`, whatever the value of `sci_en`.
- R9: In `MODE_OFF_BUTTON` (code 5, cause 1), neither of the two device wake flags drives `wake`, `sci` or `smi`.
- R10: In `MODE_OFF_POWER` (code 5, cause 2 or 3), the wake-pin flag drives nothing. The on-chip wake flag is routed as in R8.
- R11: The enabled USB flag drives `sci` or `smi` only in `MODE_RUN`. In every other mode it drives only `wake`.
- R12: Pulling `rsm_rst_n` low clears the USB status bit alone. It leaves the other status bits and all enable bits unchanged.
- R13: The battery-low flag has no enable bit and never drives `sci`, `smi` or `wake`.
- R14: A change of `slp_state` or `s5_cause` changes the routing mode after one clock edge. A change of `sci_en` takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the whole block |
| rsm_rst_n | input | 1 | Active-low asynchronous reset of the USB status bit |
| pme_int_n | input | 1 | On-chip device wake request, active low |
| usb_wake_n | input | 1 | USB controller wake request, active low |
| pme_ext_n | input | 1 | Off-chip wake pin, active low |
| batlow_n | input | 1 | Battery-low pin, active low |
| slp_state | input | 3 | Sleep-state code, 0 to 5 |
| s5_cause | input | 2 | Soft-off cause: 0 sleep-enable, 1 button override, 2 power failure |
| sci_en | input | 1 | Selects SCI (1) or SMI (0) routing |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enables |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| sci | output | 1 | SCI request level |
| smi | output | 1 | SMI request level |
| wake | output | 1 | Wake request level |

## Verification
The bench lands a hardware set on the same edge as a write-one-to-clear. A design that lets the clear win loses an event there.

It holds an input low across a clear to catch level-triggered setting, which would set the bit again at once. It walks all four routing modes with both flag sources and both `sci_en` values. Mixing up the button-override and power-failure cases, or routing the wake pin through `sci_en`, shows up as a wrong `sci`/`smi`/`wake` triple.

A resume reset is pulsed while three flags are set. A design that wipes the neighbouring flags, or keeps the USB flag, gives a wrong read value.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    // Event indices; the status bit of event i sits at register bit EVT_BASE + i
    localparam int NUM_EVT     = 4;
    localparam int EVT_BATLOW  = 0;
    localparam int EVT_PME_EXT = 1;
    localparam int EVT_USB     = 2;
    localparam int EVT_PME_INT = 3;

    localparam int SLP_W   = 3;
    localparam int CAUSE_W = 2;

    localparam logic [CAUSE_W-1:0] CAUSE_SLPEN  = 2'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_BUTTON = 2'd1;

    localparam logic ADDR_STS = 1'b0;
    localparam logic ADDR_EN  = 1'b1;

    typedef enum logic [1:0] {
        MODE_RUN,
        MODE_SLEEP,
        MODE_OFF_BUTTON,
        MODE_OFF_POWER
    } route_mode_e;

endpackage

// File: rtl/pm_evt_sync.sv
module pm_evt_sync #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] evt_n,
    output logic [NUM-1:0] fall
);

    // Two synchroniser flops plus one history flop per event
    for (genvar i = 0; i < NUM; i++) begin : g_evt
        logic meta_q, sync_q, hist_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                hist_q <= 1'b1;
            end else begin
                meta_q <= evt_n[i];
                sync_q <= meta_q;
                hist_q <= sync_q;
            end
        end

        assign fall[i] = hist_q & ~sync_q;
    end

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int EVT_BASE = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsm_rst_n,
    input  logic [NUM_EVT-1:0] set_pulse,
    input  logic               wr,
    input  logic               addr,
    input  logic [NUM_EVT-1:0] wr_bits,
    output logic [NUM_EVT-1:0] sts_q,
    output logic [NUM_EVT-1:0] en_q,
    output logic [REG_W-1:0]   rdata
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
        logic bit_rst_n;
        logic sts_r;
        logic clr;

        // The USB flag also answers to the resume-domain reset
        if (i == EVT_USB) begin : g_rsm
            assign bit_rst_n = rst_n & rsm_rst_n;
        end else begin : g_main
            assign bit_rst_n = rst_n;
        end

        assign clr = wr && (addr == ADDR_STS) && wr_bits[i];

        // Hardware set has priority over a software clear
        always_ff @(posedge clk or negedge bit_rst_n) begin
            if (!bit_rst_n)
                sts_r <= 1'b0;
            else if (set_pulse[i])
                sts_r <= 1'b1;
            else if (clr)
                sts_r <= 1'b0;
        end
        assign sts_q[i] = sts_r;

        // Battery-low carries no enable
        if (i == EVT_BATLOW) begin : g_no_en
            assign en_q[i] = 1'b0;
        end else begin : g_en
            logic en_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    en_r <= 1'b0;
                else if (wr && (addr == ADDR_EN))
                    en_r <= wr_bits[i];
            end
            assign en_q[i] = en_r;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            rdata[EVT_BASE + i] = (addr == ADDR_EN) ? en_q[i] : sts_q[i];
        end
    end

endmodule

// File: rtl/pm_evt_mode.sv
module pm_evt_mode
    import pm_evt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLP_W-1:0]   slp_state,
    input  logic [CAUSE_W-1:0] s5_cause,
    output route_mode_e        mode_q,
    output logic               is_run,
    output logic               int_ok,
    output logic               ext_ok
);

    route_mode_e mode_d;

    // Next mode from the decoded sleep inputs
    always_comb begin
        unique case (slp_state)
            3'd1, 3'd2, 3'd3, 3'd4: mode_d = MODE_SLEEP;
            3'd5: begin
                unique case (s5_cause)
                    CAUSE_SLPEN:  mode_d = MODE_SLEEP;
                    CAUSE_BUTTON: mode_d = MODE_OFF_BUTTON;
                    default:      mode_d = MODE_OFF_POWER;
                endcase
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= MODE_RUN;
        else
            mode_q <= mode_d;
    end

    // Routing permissions per state
    always_comb begin
        is_run = 1'b0;
        int_ok = 1'b0;
        ext_ok = 1'b0;
        unique case (mode_q)
            MODE_RUN:        is_run = 1'b1;
            MODE_SLEEP: begin
                int_ok = 1'b1;
                ext_ok = 1'b1;
            end
            MODE_OFF_BUTTON: ;
            MODE_OFF_POWER:  int_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/pm_evt_route.sv
module pm_evt_route
    import pm_evt_pkg::*;
(
    input  logic [NUM_EVT-1:0] sts,
    input  logic [NUM_EVT-1:0] en,
    input  logic               is_run,
    input  logic               int_ok,
    input  logic               ext_ok,
    input  logic               sci_en,
    output logic               sci,
    output logic               smi,
    output logic               wake
);

    logic [NUM_EVT-1:0] act;
    logic               act_unused;
    logic               any_run;

    assign act        = sts & en;
    assign act_unused = act[EVT_BATLOW];
    assign any_run    = is_run & (act[EVT_PME_INT] | act[EVT_PME_EXT] | act[EVT_USB]);

    always_comb begin
        sci  = (any_run & sci_en)
             | (int_ok & sci_en & act[EVT_PME_INT])
             | (ext_ok & act[EVT_PME_EXT]);
        smi  = (any_run & ~sci_en)
             | (int_ok & ~sci_en & act[EVT_PME_INT]);
        wake = (int_ok & act[EVT_PME_INT])
             | (ext_ok & act[EVT_PME_EXT])
             | (~is_run & act[EVT_USB]);
    end

endmodule

// File: rtl/pm_evt_stat.sv
module pm_evt_stat
    import pm_evt_pkg::*;
#(
    parameter int REG_W    = 16,
    parameter int EVT_BASE = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rsm_rst_n,
    input  logic               pme_int_n,
    input  logic               usb_wake_n,
    input  logic               pme_ext_n,
    input  logic               batlow_n,
    input  logic [SLP_W-1:0]   slp_state,
    input  logic [CAUSE_W-1:0] s5_cause,
    input  logic               sci_en,
    input  logic               reg_wr,
    input  logic               reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               sci,
    output logic               smi,
    output logic               wake
);

    logic [NUM_EVT-1:0] evt_n;
    logic [NUM_EVT-1:0] set_pulse;
    logic [NUM_EVT-1:0] sts_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] wr_bits;
    logic               wdata_unused;
    route_mode_e        mode_q;
    logic               is_run, int_ok, ext_ok;

    always_comb begin
        evt_n              = '1;
        evt_n[EVT_BATLOW]  = batlow_n;
        evt_n[EVT_PME_EXT] = pme_ext_n;
        evt_n[EVT_USB]     = usb_wake_n;
        evt_n[EVT_PME_INT] = pme_int_n;
    end

    assign wr_bits      = reg_wdata[EVT_BASE +: NUM_EVT];
    assign wdata_unused = ^reg_wdata;

    pm_evt_sync #(.NUM(NUM_EVT)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_n (evt_n),
        .fall  (set_pulse)
    );

    pm_evt_regs #(.REG_W(REG_W), .EVT_BASE(EVT_BASE)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsm_rst_n (rsm_rst_n),
        .set_pulse (set_pulse),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wr_bits   (wr_bits),
        .sts_q     (sts_q),
        .en_q      (en_q),
        .rdata     (reg_rdata)
    );

    pm_evt_mode i_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .slp_state (slp_state),
        .s5_cause  (s5_cause),
        .mode_q    (mode_q),
        .is_run    (is_run),
        .int_ok    (int_ok),
        .ext_ok    (ext_ok)
    );

    pm_evt_route i_route (
        .sts    (sts_q),
        .en     (en_q),
        .is_run (is_run),
        .int_ok (int_ok),
        .ext_ok (ext_ok),
        .sci_en (sci_en),
        .sci    (sci),
        .smi    (smi),
        .wake   (wake)
    );

endmodule

// File: rtl/pm_evt_stat_chk.sv
module pm_evt_stat_chk
    import pm_evt_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rsm_rst_n,
    input logic               reg_wr,
    input logic               reg_addr,
    input logic [NUM_EVT-1:0] wr_bits,
    input logic               sci_en,
    input logic               sci,
    input logic               smi,
    input logic               wake,
    input logic [NUM_EVT-1:0] sts_q,
    input logic [NUM_EVT-1:0] en_q,
    input logic [NUM_EVT-1:0] set_pulse,
    input route_mode_e        mode_q
);

    localparam logic [NUM_EVT-1:0] NO_USB = ~(NUM_EVT'(1) << EVT_USB);

    logic [NUM_EVT-1:0] clr_vec;
    logic [NUM_EVT-1:0] keep_vec;

    assign clr_vec  = (reg_wr && reg_addr == ADDR_STS) ? wr_bits : '0;
    assign keep_vec = sts_q & ~clr_vec & NO_USB;

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_pulse & NO_USB) != '0) |=>
        ((sts_q & $past(set_pulse & NO_USB)) == $past(set_pulse & NO_USB)));

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n || !rsm_rst_n)
        ((clr_vec & ~set_pulse) != '0) |=>
        ((sts_q & $past(clr_vec & ~set_pulse)) == '0));

    // R3
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_vec != '0) |=> ((sts_q & $past(keep_vec)) == $past(keep_vec)));

    // R7
    run_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN) |-> !wake);

    // R7
    run_sci_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_RUN && sci_en) |-> !smi);

    // R9
    button_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF_BUTTON) |-> (!sci && !smi));

    // R13
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_q & en_q) == '0) |-> (!sci && !smi && !wake));

endmodule

bind pm_evt_stat pm_evt_stat_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsm_rst_n (rsm_rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wr_bits   (wr_bits),
    .sci_en    (sci_en),
    .sci       (sci),
    .smi       (smi),
    .wake      (wake),
    .sts_q     (sts_q),
    .en_q      (en_q),
    .set_pulse (set_pulse),
    .mode_q    (mode_q)
);

// File: tb/test_pm_evt_stat.sv
module test_pm_evt_stat;

    typedef struct {
        string       tag;
        logic [15:0] rdata;
        logic        sci;
        logic        smi;
        logic        wake;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n, rsm_rst_n;
    logic        pme_int_n, usb_wake_n, pme_ext_n, batlow_n;
    logic [2:0]  slp_state;
    logic [1:0]  s5_cause;
    logic        sci_en, reg_wr, reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        sci, smi, wake;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    pm_evt_stat i_pm_evt_stat (
        .clk(clk), .rst_n(rst_n), .rsm_rst_n(rsm_rst_n),
        .pme_int_n(pme_int_n), .usb_wake_n(usb_wake_n),
        .pme_ext_n(pme_ext_n), .batlow_n(batlow_n),
        .slp_state(slp_state), .s5_cause(s5_cause), .sci_en(sci_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sci(sci), .smi(smi), .wake(wake)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (reg_rdata !== e.rdata || sci !== e.sci || smi !== e.smi || wake !== e.wake) begin
                fails++;
                $display("FAIL %s: got rdata=%h sci=%b smi=%b wake=%b, expected rdata=%h sci=%b smi=%b wake=%b",
                         e.tag, reg_rdata, sci, smi, wake, e.rdata, e.sci, e.smi, e.wake);
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Driver: selects the read address and queues what the monitor must see
    task automatic expect_out(input logic a, input logic [15:0] rd,
                              input logic s, input logic m, input logic w, input string tag);
        exp_t e;
        reg_addr = a;
        #1;
        e.tag = tag; e.rdata = rd; e.sci = s; e.smi = m; e.wake = w;
        exp_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic write_reg(input logic a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic drive_evt(input int idx, input logic v);
        case (idx)
            0: batlow_n   = v;
            1: pme_ext_n  = v;
            2: usb_wake_n = v;
            default: pme_int_n = v;
        endcase
    endtask

    task automatic pulse_evt(input int idx);
        drive_evt(idx, 1'b0);
        tick(1);
        drive_evt(idx, 1'b1);
        tick(3);
    endtask

    task automatic set_sleep(input logic [2:0] s, input logic [1:0] c);
        slp_state = s; s5_cause = c;
        tick(2);
    endtask

    initial begin
        rst_n = 1'b0; rsm_rst_n = 1'b1;
        pme_int_n = 1'b1; usb_wake_n = 1'b1; pme_ext_n = 1'b1; batlow_n = 1'b1;
        slp_state = 3'd0; s5_cause = 2'd0; sci_en = 1'b1;
        reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R1 status");
        expect_out(1'b1, 16'h0000, 0, 0, 0, "R1 enable");

        // R6: only bits 13..11 hold enables
        write_reg(1'b1, 16'hFFFF);
        expect_out(1'b1, 16'h3800, 0, 0, 0, "R6 enable readback");

        // R2, R7: on-chip wake in run mode
        pulse_evt(3);
        expect_out(1'b0, 16'h2000, 1, 0, 0, "R2 R7 sci route");
        sci_en = 1'b0;
        expect_out(1'b0, 16'h2000, 0, 1, 0, "R7 R14 smi route");

        // R4: write zero keeps, write one clears
        write_reg(1'b0, 16'hDFFF);
        expect_out(1'b0, 16'h2000, 0, 1, 0, "R4 zero keeps");
        write_reg(1'b0, 16'h2000);
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R4 one clears");

        // R13: battery-low is status only
        pulse_evt(0);
        expect_out(1'b0, 16'h0400, 0, 0, 0, "R13 batlow silent");
        write_reg(1'b0, 16'h0400);

        // R8: sleeping
        set_sleep(3'd3, 2'd0);
        pulse_evt(1);
        expect_out(1'b0, 16'h0800, 1, 0, 1, "R8 pin wake+sci");
        write_reg(1'b0, 16'h0800);
        pulse_evt(3);
        expect_out(1'b0, 16'h2000, 0, 1, 1, "R8 on-chip wake+smi");
        sci_en = 1'b1;
        expect_out(1'b0, 16'h2000, 1, 0, 1, "R8 on-chip wake+sci");
        sci_en = 1'b0;

        // R9: soft-off by button override
        set_sleep(3'd5, 2'd1);
        expect_out(1'b0, 16'h2000, 0, 0, 0, "R9 on-chip blocked");
        pulse_evt(1);
        expect_out(1'b0, 16'h2800, 0, 0, 0, "R9 pin blocked");

        // R10: soft-off by power failure
        set_sleep(3'd5, 2'd2);
        expect_out(1'b0, 16'h2800, 0, 1, 1, "R10 on-chip still routed");
        write_reg(1'b0, 16'h2000);
        expect_out(1'b0, 16'h0800, 0, 0, 0, "R10 pin blocked");
        set_sleep(3'd5, 2'd3);
        expect_out(1'b0, 16'h0800, 0, 0, 0, "R10 cause 3 as power fail");
        write_reg(1'b0, 16'h0800);

        // R11: USB wake routing
        sci_en = 1'b1;
        set_sleep(3'd0, 2'd0);
        pulse_evt(2);
        expect_out(1'b0, 16'h1000, 1, 0, 0, "R11 usb run sci");
        set_sleep(3'd4, 2'd0);
        expect_out(1'b0, 16'h1000, 0, 0, 1, "R11 usb sleep wake");
        set_sleep(3'd5, 2'd1);
        expect_out(1'b0, 16'h1000, 0, 0, 1, "R11 usb button-off wake");
        set_sleep(3'd0, 2'd0);

        // R12: resume reset clears only the USB flag
        pulse_evt(1);
        pulse_evt(0);
        expect_out(1'b0, 16'h1C00, 1, 0, 0, "R12 before");
        rsm_rst_n = 1'b0;
        #2;
        rsm_rst_n = 1'b1;
        expect_out(1'b0, 16'h0C00, 1, 0, 0, "R12 usb cleared");
        expect_out(1'b1, 16'h3800, 1, 0, 0, "R12 enables kept");

        // R6: disabled flags drive nothing
        write_reg(1'b1, 16'h0000);
        expect_out(1'b0, 16'h0C00, 0, 0, 0, "R6 disabled silent");
        write_reg(1'b1, 16'hFFFF);

        // R3: held level sets once only
        write_reg(1'b0, 16'hFFFF);
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R4 clear all");
        drive_evt(1, 1'b0);
        tick(4);
        expect_out(1'b0, 16'h0800, 1, 0, 0, "R3 set by held low");
        write_reg(1'b0, 16'h0800);
        tick(2);
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R3 no reset while held");
        drive_evt(1, 1'b1);
        tick(3);
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R3 rise no set");

        // R5: set and clear on the same edge
        pulse_evt(1);
        drive_evt(1, 1'b0);
        tick(2);
        write_reg(1'b0, 16'h0800);
        drive_evt(1, 1'b1);
        tick(1);
        expect_out(1'b0, 16'h0800, 1, 0, 0, "R5 set wins");
        write_reg(1'b0, 16'h0800);
        expect_out(1'b0, 16'h0000, 0, 0, 0, "R4 later clear");

        tick(2);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            summary();
            $finish;
        end
    end

endmodule